// File: doc/BRIEF.md
# Global Reset Sequencer with Strap Capture

This block produces the single chip-wide reset for a four-port power controller. Four conditions can hold the chip in reset: a supply undervoltage flag, an enable pin held low long enough, a one-shot software request written through the register bus, and an over-temperature trip with hysteresis. Any active condition asserts the reset output. After the last condition clears, the output stays asserted for a fixed number of further clock cycles.

The block also owns the configuration straps. These are a bus-address field plus three mode pins: cadence detection, high-power class enable and autonomous operation. They are captured into holding registers on the clock edge where reset releases. Strap pin changes while the chip runs have no effect until the next reset ends. The analog comparators, the temperature sensor and the register file are outside the block. It sees only their digital outputs.

Top module: `rstc_top`

## Requirements
- R1: While `uv_i` is 1, `rst_o` is 1 with no clock edge needed, and all latched strap outputs read 0.
- R2: `pin_en_i` held low for at least LOW_CYC consecutive clock cycles (100 µs at CLK_HZ; 100 cycles by default) asserts `rst_o`.
- R3: A low pulse on `pin_en_i` shorter than LOW_CYC cycles never asserts `rst_o`.
- R4: Once a pin reset has started, `rst_o` stays 1 for as long as `pin_en_i` stays low, and it releases only after the pin returns high.
- R5: A register write with `reg_addr_i` = 8'h1A and `reg_wdata_i` bit 4 = 1 asserts `rst_o` two cycles later. A write to another address, or one with bit 4 = 0, has no effect.
- R6: `swrst_rd_o` reads 1 for exactly the one cycle after the triggering write and reads 0 from then on.
- R7: `temp_i` (an unsigned whole-degree Celsius code) at or above TRIP_C (140) asserts `rst_o`. The reset is held while `temp_i` stays at or above REL_C (120).
- R8: From the cool state, any `temp_i` below TRIP_C leaves `rst_o` at 0. Codes in [REL_C, TRIP_C) keep whatever thermal state was last set.
- R9: After the last reset condition clears, `rst_o` stays 1 for at least HOLD_CYC (16) cycles and falls within HOLD_CYC+6 cycles.
- R10: The `lat_*` outputs take the values on the strap inputs at the edge where `rst_o` falls. They do not change while `rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| uv_i | input | 1 | Supply undervoltage flag, active high, asynchronous |
| pin_en_i | input | 1 | Enable pin, low requests reset, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| temp_i | input | 8 | Die temperature, unsigned whole °C |
| strap_addr_i | input | 4 | Bus address strap pins |
| strap_mid_i | input | 1 | Cadence-detection strap |
| strap_cl5_i | input | 1 | High-power class enable strap |
| strap_auto_i | input | 1 | Autonomous operation strap |
| rst_o | output | 1 | Global reset, active high |
| swrst_rd_o | output | 1 | Read-back of the self-clearing software reset bit |
| lat_addr_o | output | 4 | Latched address strap |
| lat_mid_o | output | 1 | Latched cadence strap |
| lat_cl5_o | output | 1 | Latched class enable strap |
| lat_auto_o | output | 1 | Latched autonomous strap |

## Verification
The bench sweeps enable low-pulse widths across the LOW_CYC boundary. A filter that is off by one would reset on a 99-cycle glitch or miss a 100-cycle pulse. It also sweeps the temperature code through all 256 values, first up and then down. A design without hysteresis would drop reset between 120 and 139, and a design with a wrong comparison would trip at 139 or fail to trip at 140. Software writes with the wrong address or a cleared bit 4 must not reset the chip, and the request bit must not stick. Strap pins are changed while the chip is running to catch a latch that stays transparent, and the release length is measured to catch a missing hold stretch.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int STRAP_ADDR_W = 4;
    localparam int SRC_N        = 4;

    typedef struct packed {
        logic [STRAP_ADDR_W-1:0] addr;
        logic                    mid;
        logic                    cl5;
        logic                    auto_op;
    } strap_t;
endpackage

// File: rtl/rstc_en_filter.sv
module rstc_en_filter #(
    parameter int LOW_CYC = 100
) (
    input  logic clk_i,
    input  logic uv_i,
    input  logic pin_en_i,
    output logic hw_rst_o
);
    localparam int CW = $clog2(LOW_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_en_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(LOW_CYC)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge uv_i) begin
        if (uv_i) begin
            st_q.s1  <= 1'b1;
            st_q.s2  <= 1'b1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hw_rst_o = (st_q.cnt == CW'(LOW_CYC));

    // R3
    low_time_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        $rose(hw_rst_o) |-> $past(!st_q.s2));

    // R4
    held_low_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (hw_rst_o && !st_q.s2) |=> hw_rst_o);
endmodule

// File: rtl/rstc_thermal.sv
module rstc_thermal #(
    parameter int TW     = 8,
    parameter int TRIP_C = 140,
    parameter int REL_C  = 120
) (
    input  logic          clk_i,
    input  logic          uv_i,
    input  logic [TW-1:0] temp_i,
    output logic          hot_o
);
    localparam logic [TW-1:0] TRIP_V = TW'(TRIP_C);
    localparam logic [TW-1:0] REL_V  = TW'(REL_C);

    typedef struct packed {
        logic hot;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (temp_i >= TRIP_V) begin
            st_d.hot = 1'b1;
        end else if (temp_i < REL_V) begin
            st_d.hot = 1'b0;
        end
    end

    always_ff @(posedge clk_i or posedge uv_i) begin
        if (uv_i) st_q <= '0;
        else      st_q <= st_d;
    end

    assign hot_o = st_q.hot;

    // R7
    trip_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (temp_i >= TRIP_V) |=> hot_o);

    // R7
    cool_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (temp_i < REL_V) |=> !hot_o);

    // R8
    band_hold_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (temp_i >= REL_V && temp_i < TRIP_V) |=> (hot_o == $past(hot_o)));
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int SRC_N    = 4,
    parameter int HOLD_CYC = 16
) (
    input  logic             clk_i,
    input  logic             uv_i,
    input  logic [SRC_N-1:0] src_i,
    output logic             rst_o,
    output logic             release_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic          rst;
        logic [HW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic any_src;

    assign any_src = |src_i;

    always_comb begin
        st_d = st_q;
        if (any_src) begin
            st_d.cnt = HW'(HOLD_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.rst = any_src || (st_q.cnt != '0);
    end

    always_ff @(posedge clk_i or posedge uv_i) begin
        if (uv_i) begin
            st_q.rst <= 1'b1;
            st_q.cnt <= HW'(HOLD_CYC);
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o     = st_q.rst;
    assign release_o = st_q.rst && !st_d.rst;

    // R1
    src_rst_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        any_src |=> rst_o);

    // R9
    hold_cnt_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        !rst_o |-> (st_q.cnt == '0));

    // R9
    hold_rst_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (st_q.cnt != '0) |=> rst_o);
endmodule

// File: rtl/rstc_strap.sv
module rstc_strap
    import rstc_pkg::*;
(
    input  logic   clk_i,
    input  logic   uv_i,
    input  logic   capture_i,
    input  strap_t strap_i,
    output strap_t strap_o
);
    typedef struct packed {
        strap_t val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.val = strap_i;
        end
    end

    always_ff @(posedge clk_i or posedge uv_i) begin
        if (uv_i) st_q <= '0;
        else      st_q <= st_d;
    end

    assign strap_o = st_q.val;
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int          CLK_HZ   = 1_000_000,
    parameter int          LOW_US   = 100,
    parameter int          HOLD_CYC = 16,
    parameter int          TW       = 8,
    parameter int          TRIP_C   = 140,
    parameter int          REL_C    = 120,
    parameter logic [7:0]  SW_ADDR  = 8'h1A,
    parameter int          SW_BIT   = 4
) (
    input  logic                    clk_i,
    input  logic                    uv_i,
    input  logic                    pin_en_i,
    input  logic                    reg_wr_i,
    input  logic [7:0]              reg_addr_i,
    input  logic [7:0]              reg_wdata_i,
    input  logic [TW-1:0]           temp_i,
    input  logic [STRAP_ADDR_W-1:0] strap_addr_i,
    input  logic                    strap_mid_i,
    input  logic                    strap_cl5_i,
    input  logic                    strap_auto_i,
    output logic                    rst_o,
    output logic                    swrst_rd_o,
    output logic [STRAP_ADDR_W-1:0] lat_addr_o,
    output logic                    lat_mid_o,
    output logic                    lat_cl5_o,
    output logic                    lat_auto_o
);
    localparam int LOW_CYC = (CLK_HZ / 1_000_000) * LOW_US;

    typedef struct packed {
        logic req;
    } st_t;

    st_t             st_d, st_q;
    logic            sw_hit;
    logic            hw_rst;
    logic            hot;
    logic            release_edge;
    logic [SRC_N-1:0] srcs;
    strap_t          strap_in, strap_lat;
    logic            unused_wdata;

    assign sw_hit       = reg_wr_i && (reg_addr_i == SW_ADDR) && reg_wdata_i[SW_BIT];
    assign unused_wdata = ^reg_wdata_i;

    always_comb begin
        st_d     = st_q;
        st_d.req = sw_hit;
    end

    always_ff @(posedge clk_i or posedge uv_i) begin
        if (uv_i) st_q <= '0;
        else      st_q <= st_d;
    end

    assign swrst_rd_o = st_q.req;

    rstc_en_filter #(.LOW_CYC(LOW_CYC)) en_filt_i (
        .clk_i    (clk_i),
        .uv_i     (uv_i),
        .pin_en_i (pin_en_i),
        .hw_rst_o (hw_rst)
    );

    rstc_thermal #(.TW(TW), .TRIP_C(TRIP_C), .REL_C(REL_C)) therm_i (
        .clk_i  (clk_i),
        .uv_i   (uv_i),
        .temp_i (temp_i),
        .hot_o  (hot)
    );

    assign srcs = {hot, st_q.req, hw_rst, uv_i};

    rstc_stretch #(.SRC_N(SRC_N), .HOLD_CYC(HOLD_CYC)) stretch_i (
        .clk_i     (clk_i),
        .uv_i      (uv_i),
        .src_i     (srcs),
        .rst_o     (rst_o),
        .release_o (release_edge)
    );

    assign strap_in = '{addr: strap_addr_i, mid: strap_mid_i,
                        cl5: strap_cl5_i, auto_op: strap_auto_i};

    rstc_strap strap_i (
        .clk_i     (clk_i),
        .uv_i      (uv_i),
        .capture_i (release_edge),
        .strap_i   (strap_in),
        .strap_o   (strap_lat)
    );

    assign lat_addr_o = strap_lat.addr;
    assign lat_mid_o  = strap_lat.mid;
    assign lat_cl5_o  = strap_lat.cl5;
    assign lat_auto_o = strap_lat.auto_op;

    // R1
    uv_rst_chk: assert property (@(posedge clk_i) uv_i |-> rst_o);

    // R5
    sw_rst_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        sw_hit |=> ##1 rst_o);

    // R6
    sw_clear_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (swrst_rd_o && !sw_hit) |=> !swrst_rd_o);

    // R10
    strap_frozen_chk: assert property (@(posedge clk_i) disable iff (uv_i)
        (!rst_o && $past(!rst_o)) |-> $stable(strap_lat));
endmodule

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOW   = 100;
    localparam int HOLD  = 16;
    localparam int TRIP  = 140;
    localparam int REL   = 120;

    logic       clk = 1'b0;
    logic       uv, pin_en, reg_wr;
    logic [7:0] reg_addr, reg_wdata, temp;
    logic [3:0] s_addr;
    logic       s_mid, s_cl5, s_auto;
    logic       rst, swrd;
    logic [3:0] l_addr;
    logic       l_mid, l_cl5, l_auto;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstc_top #(.CLK_HZ(1_000_000), .LOW_US(100), .HOLD_CYC(HOLD),
               .TW(8), .TRIP_C(TRIP), .REL_C(REL)) dut_i (
        .clk_i(clk), .uv_i(uv), .pin_en_i(pin_en), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .temp_i(temp),
        .strap_addr_i(s_addr), .strap_mid_i(s_mid), .strap_cl5_i(s_cl5),
        .strap_auto_i(s_auto), .rst_o(rst), .swrst_rd_o(swrd),
        .lat_addr_o(l_addr), .lat_mid_o(l_mid), .lat_cl5_o(l_cl5),
        .lat_auto_o(l_auto)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_free(output int n);
        n = 0;
        while (rst && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic watch_rst(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst) seen = 1;
        end
    endtask

    task automatic sw_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, seen;
        logic hot_m;
        uv = 1'b1; pin_en = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        temp = 8'd25; s_addr = 4'hA; s_mid = 1'b1; s_cl5 = 1'b0; s_auto = 1'b1;
        #3;
        // R1: reset state during undervoltage
        check("R1 rst during uv", int'(rst), 1);
        check("R1 straps cleared", int'({l_addr, l_mid, l_cl5, l_auto}), 0);
        repeat (5) @(negedge clk);
        check("R1 rst held", int'(rst), 1);
        uv = 1'b0;
        wait_free(n);
        // R9: hold stretch after undervoltage
        check("R9 uv release min", int'(n >= HOLD), 1);
        check("R9 uv release max", int'(n <= HOLD + 6), 1);
        // R10: straps captured at release
        check("R10 addr latched", int'(l_addr), 4'hA);
        check("R10 mode latched", int'({l_mid, l_cl5, l_auto}), 3'b101);

        // R10: changes while running are ignored
        s_addr = 4'h3; s_mid = 1'b0; s_cl5 = 1'b1; s_auto = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 addr frozen", int'(l_addr), 4'hA);
        check("R10 mode frozen", int'({l_mid, l_cl5, l_auto}), 3'b101);

        // R2/R3: sweep of low pulse widths across the boundary
        for (int w = LOW - 3; w <= LOW + 2; w++) begin
            pin_en = 1'b0;
            repeat (w) @(negedge clk);
            pin_en = 1'b1;
            watch_rst(12, seen);
            if (w < LOW) check("R3 short pulse ignored", seen, 0);
            else         check("R2 long pulse resets", seen, 1);
            wait_free(n);
            repeat (4) @(negedge clk);
        end
        // R10: new straps taken at the pin reset release
        check("R10 addr relatched", int'(l_addr), 4'h3);
        check("R10 mode relatched", int'({l_mid, l_cl5, l_auto}), 3'b010);

        // R4: held while pin low, released after it returns high
        pin_en = 1'b0;
        repeat (250) @(negedge clk);
        check("R4 held while low", int'(rst), 1);
        repeat (50) @(negedge clk);
        check("R4 still held", int'(rst), 1);
        pin_en = 1'b1;
        wait_free(n);
        check("R4 release min", int'(n >= HOLD + 1), 1);
        check("R9 pin release max", int'(n <= HOLD + 6), 1);

        // R5: writes that must not reset
        sw_write(8'h1A, 8'hEF);
        watch_rst(30, seen);
        check("R5 bit4 clear ignored", seen, 0);
        check("R6 bit reads 0 no hit", int'(swrd), 0);
        sw_write(8'h1B, 8'h10);
        watch_rst(30, seen);
        check("R5 other addr ignored", seen, 0);
        sw_write(8'h1A, 8'h10);
        check("R6 bit set after write", int'(swrd), 1);
        check("R5 not yet in reset", int'(rst), 0);
        @(negedge clk);
        check("R5 reset asserted", int'(rst), 1);
        check("R6 bit self-cleared", int'(swrd), 0);
        wait_free(n);
        check("R9 sw release min", int'(n >= HOLD), 1);
        check("R6 bit stays 0", int'(swrd), 0);

        // R7/R8: temperature sweep up then down
        hot_m = 1'b0;
        for (int t = 0; t < 256; t++) begin
            temp = 8'(t);
            if (t >= TRIP) hot_m = 1'b1;
            else if (t < REL) hot_m = 1'b0;
            repeat (HOLD + 6) @(negedge clk);
            if (t < TRIP) check("R8 cool below trip", int'(rst), int'(hot_m));
            else          check("R7 trip at or above", int'(rst), int'(hot_m));
        end
        for (int t = 255; t >= 0; t--) begin
            temp = 8'(t);
            if (t >= TRIP) hot_m = 1'b1;
            else if (t < REL) hot_m = 1'b0;
            repeat (HOLD + 6) @(negedge clk);
            if (t >= REL) check("R7 hysteresis hold", int'(rst), int'(hot_m));
            else          check("R8 released below rel", int'(rst), int'(hot_m));
        end

        // R9: thermal release length
        temp = 8'd150;
        repeat (5) @(negedge clk);
        temp = 8'd50;
        wait_free(n);
        check("R9 thermal release min", int'(n >= HOLD), 1);
        check("R9 thermal release max", int'(n <= HOLD + 6), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule